// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block records up to eight digital input channels into a small on-chip sample buffer. A capture is started either by software or, when edge triggering is selected, by a rising or falling transition on one chosen channel. Once started, every pulse of the sample strobe stores one byte holding one bit per channel. Capture halts on its own when the chosen number of samples has been stored.

Each channel reaches the buffer through an AND gate that is open only while a capture is running. The stored bytes are read out oldest first, one byte per read strobe. A two-way selector places either the current buffer byte or a status byte on the output that feeds the serial transmitter. A clear command empties the buffer and re-arms the block. The asynchronous reset is released in step with the clock.

Top module: `trig_capture`

## Requirements
- R1: After reset the block is idle: `capt_done`=0, `buf_empty`=1, `out_byte`=0x00 with `out_sel`=0 and 0x02 with `out_sel`=1.
- R2: With `trig_mode`=0, transitions on the channels never start a capture. The buffer stays empty.
- R3: With `trig_mode`=1, a capture starts when the channel picked by `trig_sel` shows an edge between two consecutive clocks. `trig_slope`=0 selects a 0-to-1 edge and `trig_slope`=1 selects a 1-to-0 edge. After reset the earlier level is taken as 0.
- R4: A `sw_start` pulse in the idle state starts a capture in either trigger mode. The capture runs from the next clock.
- R5: While capturing, each cycle with `smp_en`=1 appends `chan_in` to the buffer. A strobe in the start cycle, or outside a capture, stores nothing. Bytes are read back in the order they were written.
- R6: Capture length is 16 << `len_sel` (00=16, 01=32, 10=64, 11=128), taken at start. `capt_done` rises with the write of the last sample, and no further sample is stored.
- R7: Start conditions (software or trigger) are ignored while capturing or after completion. `capt_done` holds until a clear.
- R8: `clr`=1 empties the buffer, zeroes the sample count, drops `capt_done` and returns to idle in one cycle. It overrides a start, a write or a read in the same cycle.
- R9: `rd_strobe` advances the read position by one when the buffer holds data. It is ignored when empty. `buf_empty` is 1 exactly when every written byte has been read, and the buffer byte reads 0x00 then.
- R10: With `out_sel`=1, `out_byte` is the status byte: bit0 = capture done, bit1 = buffer empty, bit2 = capturing, upper bits 0. With `out_sel`=0 it is the buffer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | 8 | Channel levels |
| smp_en | input | 1 | Sample strobe |
| sw_start | input | 1 | Software start pulse |
| clr | input | 1 | Clear buffer and re-arm |
| trig_mode | input | 1 | 0 software only, 1 edge trigger |
| trig_slope | input | 1 | 0 rising, 1 falling |
| trig_sel | input | 3 | Trigger channel index |
| len_sel | input | 2 | Capture length select |
| rd_strobe | input | 1 | Advance read position |
| out_sel | input | 1 | 0 buffer byte, 1 status byte |
| out_byte | output | 8 | Selected byte to transmitter |
| capt_done | output | 1 | Capture complete |
| buf_empty | output | 1 | No unread bytes |

## Verification
The bench uses the default build: eight channels, a 128-entry buffer and a 16-sample minimum length. All four length codes are therefore reachable, up to the 128-sample capture that fills every entry. That last case tests the point where the read and write positions match on a full buffer, which must not read as empty. Rising and falling triggers are run on different channels. Clear is exercised mid-capture and together with a start.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cap_state_t;

  localparam int unsigned STAT_DONE_BIT  = 0;
  localparam int unsigned STAT_EMPTY_BIT = 1;
  localparam int unsigned STAT_RUN_BIT   = 2;
  localparam int unsigned STAT_USED      = 3;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             trig_slope,
  output logic             edge_hit
);
  logic cur_lvl;
  logic prev_q;
  logic prev_d;

  always_comb begin
    cur_lvl = chan_in[trig_sel];
    prev_d  = cur_lvl;
    if (trig_slope) edge_hit = prev_q & ~cur_lvl;
    else            edge_hit = cur_lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int unsigned PW        = 8,
  parameter int unsigned LEN_SEL_W = 2,
  parameter int unsigned MIN_LEN   = 16
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 clr,
  input  logic                 sw_start,
  input  logic                 trig_mode,
  input  logic                 edge_hit,
  input  logic                 smp_en,
  input  logic [LEN_SEL_W-1:0] len_sel,
  output logic                 wr_en,
  output logic                 capturing,
  output logic                 capt_done
);
  cap_state_t     st_q, st_d;
  logic [PW-1:0]  cnt_q, cnt_d;
  logic [PW-1:0]  len_q, len_d;
  logic           start_cond;
  logic [PW-1:0]  cnt_inc;

  always_comb begin
    start_cond = sw_start | (trig_mode & edge_hit);
    wr_en      = (st_q == ST_RUN) & smp_en & ~clr;
    cnt_inc    = cnt_q + PW'(1);
    st_d       = st_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    if (clr) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_cond) begin
            st_d  = ST_RUN;
            cnt_d = '0;
            len_d = PW'(MIN_LEN) << len_sel;
          end
        end
        ST_RUN: begin
          if (wr_en) begin
            cnt_d = cnt_inc;
            if (cnt_inc == len_q) st_d = ST_DONE;
          end
        end
        ST_DONE: st_d = ST_DONE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= PW'(MIN_LEN);
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign capturing = (st_q == ST_RUN);
  assign capt_done = (st_q == ST_DONE);
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = 7,
  parameter int unsigned PW    = 8
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            clr,
  input  logic            capturing,
  input  logic [CH_W-1:0] chan_in,
  input  logic            wr_en,
  input  logic            rd_strobe,
  output logic [CH_W-1:0] rd_data,
  output logic            buf_empty,
  output logic [PW-1:0]   wr_ptr,
  output logic [PW-1:0]   rd_ptr
);
  logic [CH_W-1:0] gated;
  logic [CH_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]   wp_q, wp_d;
  logic [PW-1:0]   rp_q, rp_d;
  logic            rd_ok;

  for (genvar g = 0; g < CH_W; g++) begin : g_gate
    assign gated[g] = chan_in[g] & capturing;
  end

  always_comb begin
    buf_empty = (rp_q == wp_q);
    rd_ok     = rd_strobe & ~buf_empty & ~clr;
    wp_d      = wp_q;
    rp_d      = rp_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (wr_en) wp_d = wp_q + PW'(1);
      if (rd_ok) rp_d = rp_q + PW'(1);
    end
    rd_data = buf_empty ? '0 : mem_q[rp_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q[AW-1:0]] <= gated;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
endmodule

// File: rtl/cap_outmux.sv
module cap_outmux
  import cap_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0] buf_data,
  input  logic            st_done,
  input  logic            st_empty,
  input  logic            st_run,
  input  logic            out_sel,
  output logic [CH_W-1:0] out_byte
);
  logic [CH_W-1:0] stat_byte;

  for (genvar g = 0; g < CH_W; g++) begin : g_stat
    if (g == STAT_DONE_BIT) begin : g_done
      assign stat_byte[g] = st_done;
    end else if (g == STAT_EMPTY_BIT) begin : g_empty
      assign stat_byte[g] = st_empty;
    end else if (g == STAT_RUN_BIT) begin : g_run
      assign stat_byte[g] = st_run;
    end else begin : g_pad
      assign stat_byte[g] = 1'b0;
    end
  end

  always_comb begin
    out_byte = out_sel ? stat_byte : buf_data;
  end
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int unsigned CH_W      = 8,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned LEN_SEL_W = 2,
  parameter int unsigned MIN_LEN   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CH_W-1:0]          chan_in,
  input  logic                     smp_en,
  input  logic                     sw_start,
  input  logic                     clr,
  input  logic                     trig_mode,
  input  logic                     trig_slope,
  input  logic [$clog2(CH_W)-1:0]  trig_sel,
  input  logic [LEN_SEL_W-1:0]     len_sel,
  input  logic                     rd_strobe,
  input  logic                     out_sel,
  output logic [CH_W-1:0]          out_byte,
  output logic                     capt_done,
  output logic                     buf_empty
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned SEL_W = $clog2(CH_W);

  logic            rst_sn;
  logic            edge_hit;
  logic            wr_en;
  logic            capturing;
  logic [CH_W-1:0] buf_data;
  logic [PW-1:0]   wr_ptr;
  logic [PW-1:0]   rd_ptr;

  cap_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  cap_trigger #(.CH_W(CH_W), .SEL_W(SEL_W)) u_trig (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .chan_in    (chan_in),
    .trig_sel   (trig_sel),
    .trig_slope (trig_slope),
    .edge_hit   (edge_hit)
  );

  cap_ctrl #(.PW(PW), .LEN_SEL_W(LEN_SEL_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .clr       (clr),
    .sw_start  (sw_start),
    .trig_mode (trig_mode),
    .edge_hit  (edge_hit),
    .smp_en    (smp_en),
    .len_sel   (len_sel),
    .wr_en     (wr_en),
    .capturing (capturing),
    .capt_done (capt_done)
  );

  cap_buffer #(.CH_W(CH_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_buf (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .clr       (clr),
    .capturing (capturing),
    .chan_in   (chan_in),
    .wr_en     (wr_en),
    .rd_strobe (rd_strobe),
    .rd_data   (buf_data),
    .buf_empty (buf_empty),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
  );

  cap_outmux #(.CH_W(CH_W)) u_mux (
    .buf_data (buf_data),
    .st_done  (capt_done),
    .st_empty (buf_empty),
    .st_run   (capturing),
    .out_sel  (out_sel),
    .out_byte (out_byte)
  );
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DEPTH = 128,
  parameter int unsigned PW    = 8
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            clr,
  input logic            rd_strobe,
  input logic            out_sel,
  input logic            wr_en,
  input logic            capt_done,
  input logic            buf_empty,
  input logic [PW-1:0]   wr_ptr,
  input logic [PW-1:0]   rd_ptr,
  input logic [CH_W-1:0] out_byte
);
  p_done_no_write_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    capt_done |-> !wr_en);

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_ptr <= PW'(DEPTH));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (capt_done && !clr) |=> capt_done);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    clr |=> (!capt_done && buf_empty && wr_ptr == '0));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (buf_empty && rd_strobe && !clr) |=> $stable(rd_ptr));

  p_ptr_order_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_ptr <= wr_ptr);

  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |=> !buf_empty);

  p_status_pad_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    out_sel |-> (out_byte[CH_W-1:3] == '0));
endmodule

bind trig_capture trig_capture_chk #(.CH_W(CH_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .clr       (clr),
  .rd_strobe (rd_strobe),
  .out_sel   (out_sel),
  .wr_en     (wr_en),
  .capt_done (capt_done),
  .buf_empty (buf_empty),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .out_byte  (out_byte)
);

// File: tb/trig_capture_tb.sv
`timescale 1ns/1ps
module trig_capture_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] chan;
  logic       smp, sw, clr, mode, slope, rd, osel;
  logic [2:0] sel;
  logic [1:0] lsel;
  logic [7:0] out_byte;
  logic       capt_done, buf_empty;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  bit run_model = 0;

  int         m_st, m_cnt, m_len, m_rd;
  logic       m_prev;
  logic [7:0] m_q[$];
  int         reads;

  trig_capture u_dut (
    .clk(clk), .rst_n(rst_n), .chan_in(chan), .smp_en(smp), .sw_start(sw),
    .clr(clr), .trig_mode(mode), .trig_slope(slope), .trig_sel(sel),
    .len_sel(lsel), .rd_strobe(rd), .out_sel(osel), .out_byte(out_byte),
    .capt_done(capt_done), .buf_empty(buf_empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic cur, edge_hit, empty_old;
    cur = chan[sel];
    edge_hit = slope ? (m_prev & !cur) : (cur & !m_prev);
    empty_old = (m_rd == m_q.size());
    if (clr) begin
      m_q.delete(); m_rd = 0; m_cnt = 0; m_st = 0;
    end else begin
      if (rd && !empty_old) m_rd++;
      case (m_st)
        0: if (sw || (mode && edge_hit)) begin m_st = 1; m_cnt = 0; m_len = 16 << lsel; end
        1: if (smp) begin
             m_q.push_back(chan); m_cnt++;
             if (m_cnt == m_len) m_st = 2;
           end
        default: ;
      endcase
    end
    m_prev = cur;
  endtask

  task automatic compare();
    logic e_empty, e_done;
    logic [7:0] e_buf, e_stat;
    e_empty = (m_rd == m_q.size());
    e_done  = (m_st == 2);
    e_buf   = e_empty ? 8'h00 : m_q[m_rd];
    e_stat  = {5'b0, (m_st == 1), e_empty, e_done};
    check(out_byte, osel ? e_stat : e_buf, osel ? "R10" : "R5");
    check(capt_done, e_done, "R6");
    check(buf_empty, e_empty, "R9");
  endtask

  task automatic cyc();
    if (rd && !buf_empty && !clr) reads++;
    @(posedge clk);
    if (run_model) model_step();
    @(negedge clk);
    #0.5;
    compare();
  endtask

  task automatic idle_inputs();
    smp = 0; sw = 0; clr = 0; rd = 0;
  endtask

  task automatic run(input int n, input int per, input bit do_rd, input bit do_rnd);
    for (int i = 0; i < n; i++) begin
      if (do_rnd) chan = 8'($urandom);
      smp  = ((i % per) == 0);
      rd   = do_rd ? ($urandom_range(0, 2) == 0) : 1'b0;
      osel = ($urandom_range(0, 3) == 0);
      cyc();
    end
    idle_inputs();
    osel = 0;
  endtask

  task automatic drain(input int n);
    reads = 0;
    rd = 1;
    for (int i = 0; i < n; i++) begin
      osel = (i % 5 == 4);
      cyc();
    end
    rd = 0; osel = 0;
  endtask

  task automatic do_clear();
    clr = 1; cyc(); clr = 0;
  endtask

  initial begin
    rst_n = 0; chan = 0; smp = 0; sw = 0; clr = 0; mode = 0; slope = 0;
    rd = 0; osel = 0; sel = 0; lsel = 0; reads = 0;
    m_st = 0; m_cnt = 0; m_len = 16; m_rd = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    #0.5;
    // R1: reset state
    check(capt_done, 0, "R1");
    check(buf_empty, 1, "R1");
    check(out_byte, 8'h00, "R1");
    osel = 1; #0.5;
    check(out_byte, 8'h02, "R1");
    osel = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_model = 1;
    #0.5;
    compare();

    // R2: software-only mode ignores channel edges
    mode = 0; slope = 0; sel = 1;
    run(30, 1, 0, 1);
    check(buf_empty, 1, "R2");
    check(capt_done, 0, "R2");

    // R4 R5 R6 R7: software start, 16 samples, start pulses and len change mid-run
    lsel = 2'b00;
    sw = 1; smp = 1; chan = 8'hA5; cyc();
    sw = 0; smp = 0;
    check(buf_empty, 1, "R5");
    osel = 1; #0.5; check(out_byte, 8'h06, "R4"); osel = 0;
    run(10, 3, 0, 1);
    lsel = 2'b11; sw = 1; cyc(); sw = 0;
    run(60, 3, 0, 1);
    check(capt_done, 1, "R6");
    sw = 1; smp = 1; cyc(); idle_inputs();
    check(capt_done, 1, "R7");
    drain(22);
    check(reads, 16, "R6");
    check(buf_empty, 1, "R9");

    // R8: clear together with start
    sw = 1; clr = 1; cyc(); idle_inputs();
    check(capt_done, 0, "R8");
    check(buf_empty, 1, "R8");
    osel = 1; #0.5; check(out_byte, 8'h02, "R8"); osel = 0;

    // R3: rising edge on channel 3, 32 samples, reads during capture
    mode = 1; slope = 0; sel = 3; lsel = 2'b01;
    for (int i = 0; i < 8; i++) begin chan = 8'($urandom) & 8'hF7; cyc(); end
    check(buf_empty, 1, "R3");
    chan = 8'h08; cyc();
    osel = 1; #0.5; check(out_byte[2], 1, "R3"); osel = 0;
    run(70, 1, 1, 1);
    check(capt_done, 1, "R3");
    drain(40);
    do_clear();

    // R3: falling edge on channel 5, 64 samples
    slope = 1; sel = 5; lsel = 2'b10;
    chan = 8'h20; repeat (4) cyc();
    check(buf_empty, 1, "R3");
    chan = 8'h00; cyc();
    run(100, 1, 1, 1);
    check(capt_done, 1, "R3");
    drain(70);
    do_clear();

    // R6 R9: full 128-sample buffer, software start in trigger mode
    slope = 0; sel = 0; lsel = 2'b11; chan = 8'h01;
    sw = 1; cyc(); sw = 0;
    run(300, 2, 0, 1);
    check(capt_done, 1, "R6");
    check(buf_empty, 0, "R9");
    drain(135);
    check(reads, 128, "R6");
    check(buf_empty, 1, "R9");
    do_clear();

    // R8: clear mid-capture with a strobe in the same cycle
    mode = 0; lsel = 2'b00;
    sw = 1; cyc(); sw = 0;
    run(10, 1, 0, 1);
    clr = 1; smp = 1; rd = 1; cyc(); idle_inputs();
    check(buf_empty, 1, "R8");
    check(capt_done, 0, "R8");
    run(10, 1, 1, 1);
    check(buf_empty, 1, "R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule